// File: doc/BRIEF.md
# Hash Bucket Slot Lookup

This block searches one hash bucket that has already been fetched from memory. A caller hands it the bucket word, the requested key and the key's full hash. Every slot in the bucket carries a short secondary hash. The block compares all of these tags against the request at the same time, so only a few slots remain as candidates.

A slot can hold one of two things. It can hold a pointer to an entry stored outside the bucket, in which case the block returns that address so the caller can fetch it and compare the full key. It can also be the head of a small key-value pair stored inline in the bucket. For an inline head the block compares the full key itself and returns where the value lies inside the bucket. Two bitmaps in the bucket metadata tell the two kinds apart.

Results come out one at a time, lowest slot first. After a pointer candidate the caller can ask for the next match, or it can drop the search by issuing a new request.

Top module: `bkt_slot_lookup`

## Requirements
- R1: After reset, `res_valid` is low and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its first result is presented in the following cycle. While `res_valid` is high, `req_ready` is low.
- R3: A presented result keeps all of its fields unchanged until it is taken by `res_ready`. Requests offered during that time are not taken.
- R4: Slot i occupies bucket bits [i*42 +: 42]. Its bits [31:0] hold the address or the inline payload, and its bits [41:32] hold the tag. The tag is compared with the top 10 bits of `req_hash`. The inline bitmap sits at bits [343:336] and the head bitmap at bits [351:344].
- R5: A slot is a pointer match when its inline bit is clear, its address is nonzero and its tag is equal. It is reported with code 1 and `res_addr` set to the slot address.
- R6: A slot whose inline bit is clear and whose address is zero is empty and never matches.
- R7: A slot with both its inline bit and its head bit set is an inline head. It matches only when the tag is equal and payload bits [15:0] equal `req_key`. It is reported with code 2, `res_voff` = slot+1 and `res_vlen` = payload bits [18:16].
- R8: A slot with its inline bit set and its head bit clear never matches. A head bit without the inline bit is ignored, and that slot is treated as a pointer slot.
- R9: When several slots match, the lowest index is reported first.
- R10: After a code-1 result is taken, a `nxt_req` pulse presents the next higher match. When no match remains, the result is code 0 (miss). `nxt_req` has no effect in any other state.
- R11: A new request taken after a code-1 result abandons the old search and starts over at slot 0.
- R12: `res_addr` is zero for codes 0 and 2. `res_voff` and `res_vlen` are zero for codes 0 and 1. Code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_bucket | input | 352 | Bucket word: slots plus metadata bitmaps |
| req_key | input | 16 | Requested key, used for inline compare |
| req_hash | input | 32 | Full hash of the key |
| nxt_req | input | 1 | Continue the search after a pointer result |
| res_valid | output | 1 | Result presented |
| res_ready | input | 1 | Result taken |
| res_code | output | 2 | 0 miss, 1 pointer candidate, 2 inline hit |
| res_slot | output | 3 | Slot index of the reported match |
| res_addr | output | 32 | Out-of-bucket address for code 1 |
| res_voff | output | 4 | Value offset in slots for code 2 |
| res_vlen | output | 3 | Value length in slots for code 2 |

## Verification
The bench builds the block with its default parameters: eight slots, 32-bit addresses, 10-bit tags and 16-bit inline keys. With these values the bench places inline heads, their data slots and pointer slots in one bucket. It can therefore reach several cases: a data slot whose tag or key bits happen to match, an empty slot that carries a matching tag, a head bit on the last slot with no inline bit, and an inline head that only turns up after a pointer candidate. Search chains are walked to exhaustion, and one chain is abandoned partway through.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

   typedef enum logic [1:0] {
      RC_MISS   = 2'd0,
      RC_PTR    = 2'd1,
      RC_INLINE = 2'd2
   } rc_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SHOW = 2'd1,
      ST_HOLD = 2'd2
   } st_e;

endpackage

// File: rtl/bsl_slot_decode.sv
module bsl_slot_decode #(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 10,
   parameter int KEY_W  = 16,
   parameter int LEN_W  = 3,
   localparam int SLOT_W = ADDR_W + TAG_W
) (
   input  logic [SLOT_W-1:0] slot_i,
   input  logic              inl_i,
   input  logic              head_i,
   input  logic [TAG_W-1:0]  qtag_i,
   input  logic [KEY_W-1:0]  qkey_i,
   output logic              ptr_hit_o,
   output logic              inl_hit_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LEN_W-1:0]  vlen_o
);

   logic tag_eq;

   always_comb begin
      addr_o    = slot_i[ADDR_W-1:0];
      tag_eq    = (slot_i[SLOT_W-1 -: TAG_W] == qtag_i);
      ptr_hit_o = !inl_i && tag_eq && (|addr_o);
      inl_hit_o = inl_i && head_i && tag_eq && (addr_o[KEY_W-1:0] == qkey_i);
      vlen_o    = addr_o[KEY_W +: LEN_W];
   end

endmodule

// File: rtl/bsl_first_pick.sv
module bsl_first_pick #(
   parameter int N = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vec_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      found_o = |vec_i;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/bkt_slot_lookup.sv
module bkt_slot_lookup
   import bsl_pkg::*;
#(
   parameter int SLOTS  = 8,
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 10,
   parameter int HASH_W = 32,
   parameter int KEY_W  = 16,
   parameter int LEN_W  = 3,
   localparam int SLOT_W = ADDR_W + TAG_W,
   localparam int META_O = SLOTS * SLOT_W,
   localparam int BKT_W  = META_O + 2 * SLOTS,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int OFF_W  = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BKT_W-1:0]  req_bucket,
   input  logic [KEY_W-1:0]  req_key,
   input  logic [HASH_W-1:0] req_hash,
   input  logic              nxt_req,
   output logic              res_valid,
   input  logic              res_ready,
   output logic [1:0]        res_code,
   output logic [IDX_W-1:0]  res_slot,
   output logic [ADDR_W-1:0] res_addr,
   output logic [OFF_W-1:0]  res_voff,
   output logic [LEN_W-1:0]  res_vlen
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("bkt_slot_lookup: SLOTS must be at least 2");
   end
   if (KEY_W + LEN_W > ADDR_W) begin : g_bad_payload
      $error("bkt_slot_lookup: key and length do not fit a slot payload");
   end
   if (TAG_W > HASH_W) begin : g_bad_tag
      $error("bkt_slot_lookup: tag wider than hash");
   end

   st_e               state_q;
   logic [BKT_W-1:0]  bkt_q;
   logic [KEY_W-1:0]  key_q;
   logic [TAG_W-1:0]  tag_q;
   logic [SLOTS-1:0]  mask_q;

   logic [SLOTS-1:0]  ptr_hit, inl_hit, cand, above;
   logic [ADDR_W-1:0] addr_a [SLOTS];
   logic [LEN_W-1:0]  vlen_a [SLOTS];
   logic              found;
   logic [IDX_W-1:0]  pick;
   rc_e               code;
   logic              take_req, take_res;
   logic              unused_hash_lo;

   assign unused_hash_lo = ^req_hash[HASH_W-TAG_W-1:0];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      bsl_slot_decode #(
         .ADDR_W(ADDR_W), .TAG_W(TAG_W), .KEY_W(KEY_W), .LEN_W(LEN_W)
      ) u_dec (
         .slot_i    (bkt_q[s*SLOT_W +: SLOT_W]),
         .inl_i     (bkt_q[META_O + s]),
         .head_i    (bkt_q[META_O + SLOTS + s]),
         .qtag_i    (tag_q),
         .qkey_i    (key_q),
         .ptr_hit_o (ptr_hit[s]),
         .inl_hit_o (inl_hit[s]),
         .addr_o    (addr_a[s]),
         .vlen_o    (vlen_a[s])
      );
   end

   assign cand = (ptr_hit | inl_hit) & mask_q;

   bsl_first_pick #(.N(SLOTS)) u_pick (
      .vec_i   (cand),
      .found_o (found),
      .idx_o   (pick)
   );

   always_comb begin
      if (!found)             code = RC_MISS;
      else if (inl_hit[pick]) code = RC_INLINE;
      else                    code = RC_PTR;
      for (int i = 0; i < SLOTS; i++) above[i] = (i > int'(pick));
   end

   assign res_valid = (state_q == ST_SHOW);
   assign req_ready = (state_q == ST_IDLE) || ((state_q == ST_HOLD) && !nxt_req);
   assign res_code  = code;
   assign res_slot  = found ? pick : '0;
   assign res_addr  = (code == RC_PTR) ? addr_a[pick] : '0;
   assign res_voff  = (code == RC_INLINE) ? OFF_W'(pick) + OFF_W'(1) : '0;
   assign res_vlen  = (code == RC_INLINE) ? vlen_a[pick] : '0;

   assign take_req  = req_valid && req_ready;
   assign take_res  = res_valid && res_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bkt_q   <= '0;
         key_q   <= '0;
         tag_q   <= '0;
         mask_q  <= '0;
      end else begin
         if (take_req) begin
            bkt_q   <= req_bucket;
            key_q   <= req_key;
            tag_q   <= req_hash[HASH_W-1 -: TAG_W];
            mask_q  <= '1;
            state_q <= ST_SHOW;
         end else if (take_res) begin
            if (code == RC_PTR) begin
               mask_q  <= mask_q & above;
               state_q <= ST_HOLD;
            end else begin
               state_q <= ST_IDLE;
            end
         end else if ((state_q == ST_HOLD) && nxt_req) begin
            state_q <= ST_SHOW;
         end
      end
   end

endmodule

// File: rtl/bsl_checker.sv
module bsl_checker #(
   parameter int IDX_W  = 3,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              res_valid,
   input logic              res_ready,
   input logic [1:0]        res_code,
   input logic [IDX_W-1:0]  res_slot,
   input logic [ADDR_W-1:0] res_addr
);

   logic             chain_q;
   logic [IDX_W-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= 1'b0;
         last_q  <= '0;
      end else if (req_valid && req_ready) begin
         chain_q <= 1'b0;
      end else if (res_valid && res_ready && res_code == 2'd1) begin
         chain_q <= 1'b1;
         last_q  <= res_slot;
      end
   end

   // R2
   res_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> res_valid);

   // R2
   no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !req_ready);

   // R3
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_ready |=> res_valid && $stable(res_code)
                                  && $stable(res_slot) && $stable(res_addr));

   // R5
   ptr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_code == 2'd1 |-> res_addr != '0);

   // R12
   addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_code != 2'd1 |-> res_addr == '0);

   // R12
   code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_code != 2'd3);

   // R10
   next_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && chain_q && res_code != 2'd0 |-> res_slot > last_q);

endmodule

bind bkt_slot_lookup bsl_checker #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bkt_slot_lookup_tb_top.sv
module bkt_slot_lookup_tb_top;

   localparam int BKT_W = 352;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [351:0] req_bucket = '0;
   logic [15:0]  req_key = '0;
   logic [31:0]  req_hash = '0;
   logic         nxt_req = 1'b0;
   logic         res_valid;
   logic         res_ready = 1'b0;
   logic [1:0]   res_code;
   logic [2:0]   res_slot;
   logic [31:0]  res_addr;
   logic [3:0]   res_voff;
   logic [2:0]   res_vlen;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bkt_slot_lookup dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_bucket(req_bucket), .req_key(req_key), .req_hash(req_hash),
      .nxt_req(nxt_req),
      .res_valid(res_valid), .res_ready(res_ready),
      .res_code(res_code), .res_slot(res_slot), .res_addr(res_addr),
      .res_voff(res_voff), .res_vlen(res_vlen)
   );

   typedef struct packed {
      logic [9:0]  tag;
      logic [15:0] key;
      logic [1:0]  code;
      logic [2:0]  slot;
      logic [31:0] addr;
      logic [3:0]  voff;
      logic [2:0]  vlen;
   } vec_t;

   // R4 R5 R6 R7 R8 R9 against bucket A
   localparam vec_t VECS [6] = '{
      '{10'h011, 16'h0000, 2'd1, 3'd0, 32'h1000_0000, 4'd0, 3'd0},
      '{10'h022, 16'hBEEF, 2'd2, 3'd1, 32'h0,         4'd2, 3'd2},
      '{10'h022, 16'hBEEE, 2'd0, 3'd0, 32'h0,         4'd0, 3'd0},
      '{10'h033, 16'h0000, 2'd1, 3'd6, 32'h6000_0006, 4'd0, 3'd0},
      '{10'h055, 16'h0000, 2'd1, 3'd7, 32'h7000_0007, 4'd0, 3'd0},
      '{10'h3FF, 16'h0000, 2'd0, 3'd0, 32'h0,         4'd0, 3'd0}
   };

   function automatic logic [BKT_W-1:0] put(logic [BKT_W-1:0] b, int i,
                                            logic [9:0] t, logic [31:0] low);
      b[i*42 +: 42] = {t, low};
      return b;
   endfunction

   function automatic logic [BKT_W-1:0] bucket_a();
      logic [BKT_W-1:0] b = '0;
      b = put(b, 0, 10'h011, 32'h1000_0000);
      b = put(b, 1, 10'h022, {13'h0, 3'd2, 16'hBEEF});
      b = put(b, 2, 10'h022, 32'hDEAD_BEEF);
      b = put(b, 3, 10'h011, 32'h1234_5678);
      b = put(b, 4, 10'h011, 32'h4000_0004);
      b = put(b, 5, 10'h033, 32'h0);
      b = put(b, 6, 10'h033, 32'h6000_0006);
      b = put(b, 7, 10'h055, 32'h7000_0007);
      b[336 +: 8] = 8'b0000_1110;
      b[344 +: 8] = 8'b1000_0010;
      return b;
   endfunction

   function automatic logic [BKT_W-1:0] bucket_b();
      logic [BKT_W-1:0] b = '0;
      b = put(b, 0, 10'h0AA, 32'h0000_00A0);
      b = put(b, 3, 10'h0AA, {13'h0, 3'd1, 16'h5555});
      b = put(b, 4, 10'h0AA, 32'h0000_0099);
      b = put(b, 5, 10'h0AA, 32'h0000_00B5);
      b[336 +: 8] = 8'b0001_1000;
      b[344 +: 8] = 8'b0000_1000;
      return b;
   endfunction

   task automatic check_bit(input string rq, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", rq, got, exp);
      end
   endtask

   task automatic check_res(input string rq, input logic [1:0] c, input logic [2:0] s,
                            input logic [31:0] a, input logic [3:0] vo, input logic [2:0] vl);
      checks++;
      if (res_valid !== 1'b1 || res_code !== c || (c != 2'd0 && res_slot !== s) ||
          res_addr !== a || res_voff !== vo || res_vlen !== vl) begin
         errors++;
         $display("FAIL %s: got v=%0b code=%0d slot=%0d addr=%h voff=%0d vlen=%0d expected code=%0d slot=%0d addr=%h voff=%0d vlen=%0d",
                  rq, res_valid, res_code, res_slot, res_addr, res_voff, res_vlen,
                  c, s, a, vo, vl);
      end
   endtask

   task automatic send(input logic [BKT_W-1:0] b, input logic [9:0] t, input logic [15:0] k);
      @(negedge clk);
      req_bucket = b;
      req_key    = k;
      req_hash   = {t, 22'h2A5A5};
      req_valid  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid  = 1'b0;
   endtask

   task automatic take();
      res_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      res_ready = 1'b0;
   endtask

   task automatic more();
      nxt_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      nxt_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check_bit("R1 res_valid after reset", res_valid, 1'b0);
      check_bit("R1 req_ready after reset", req_ready, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk; each new request abandons a held pointer search (R11)
      for (int v = 0; v < 6; v++) begin
         send(bucket_a(), VECS[v].tag, VECS[v].key);
         check_res($sformatf("R2 R5 R7 R8 R9 R11 vector %0d", v), VECS[v].code,
                   VECS[v].slot, VECS[v].addr, VECS[v].voff, VECS[v].vlen);
         take();
      end

      // R10: chain over tag 011; slot3 is inline data and is skipped (R8)
      send(bucket_a(), 10'h011, 16'h0);
      check_res("R9 chain first", 2'd1, 3'd0, 32'h1000_0000, 4'd0, 3'd0);
      take();
      more();
      check_res("R10 chain second", 2'd1, 3'd4, 32'h4000_0004, 4'd0, 3'd0);
      take();
      more();
      check_res("R10 chain exhausted", 2'd0, 3'd0, 32'h0, 4'd0, 3'd0);
      take();
      check_bit("R10 idle after miss", req_ready, 1'b1);

      // R10: nxt_req while idle has no effect
      more();
      check_bit("R10 nxt ignored valid", res_valid, 1'b0);
      check_bit("R10 nxt ignored ready", req_ready, 1'b1);

      // R7 R9: inline head found after a pointer candidate
      send(bucket_b(), 10'h0AA, 16'h5555);
      check_res("R9 bucket B first", 2'd1, 3'd0, 32'h0000_00A0, 4'd0, 3'd0);
      take();
      more();
      check_res("R7 bucket B inline", 2'd2, 3'd3, 32'h0, 4'd4, 3'd1);
      take();

      // R7: key mismatch skips the head, continues to slot5, then miss
      send(bucket_b(), 10'h0AA, 16'h5556);
      check_res("R7 mismatch first", 2'd1, 3'd0, 32'h0000_00A0, 4'd0, 3'd0);
      take();
      more();
      check_res("R7 mismatch skips head", 2'd1, 3'd5, 32'h0000_00B5, 4'd0, 3'd0);
      take();
      more();
      check_res("R10 bucket B exhausted", 2'd0, 3'd0, 32'h0, 4'd0, 3'd0);
      take();

      // R3: hold under backpressure, with a competing request offered
      send(bucket_a(), 10'h033, 16'h0);
      req_bucket = bucket_b();
      req_hash   = {10'h0AA, 22'h0};
      req_valid  = 1'b1;
      for (int w = 0; w < 3; w++) begin
         @(negedge clk);
         check_res("R3 held result", 2'd1, 3'd6, 32'h6000_0006, 4'd0, 3'd0);
         check_bit("R3 request blocked", req_ready, 1'b0);
      end
      req_valid = 1'b0;
      take();
      check_bit("R3 no result after take", res_valid, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule